// File: doc/BRIEF.md
# Polling Serial Converter Reader

This block is the host side of a three-wire link to a sampling converter that is clocked from outside. When the host asks for a reading, the reader pulls the active-low select line down while its serial clock sits low. This tells the converter to take its clock from the host. The reader then watches the data line, which the converter uses as a busy flag for as long as a conversion runs. Only after the flag has read as clear does the reader produce 24 serial clock pulses. It samples the data line on each rising edge, so the first bit it takes is the flag and the remaining 23 bits are the result.

The serial clock half-period is set in system clocks, and the reader never lets it drop below two. While waiting for the converter, the reader can either keep the select line low or release it for a programmable idle gap between status checks. An optional poll limit stops a converter that never becomes ready from hanging the reader. An abort input raises select at once. This discards a partial frame and makes the converter start a new conversion. A finished frame counts only when its first sampled bit is zero. Such a frame is reported with a one-cycle valid pulse after select has been released. A frame whose first bit is one raises the error flag instead.

Top module: `adc_serial_reader`

## Requirements
- R1: Every falling edge of `cs_no` happens while `sck_o` is low, and `sck_o` is high only while `cs_no` is low.
- R2: After each falling edge of `cs_no`, the reader waits one half-period and then samples `sdo_i` as a status flag. A 1 means busy, and further checks follow.
- R3: No rising edge of `sck_o` occurs until the status flag has read 0. After that, exactly 24 rising edges are produced per frame.
- R4: Both the high and the low phase of `sck_o` last max(2, `half_div_i`) system clocks.
- R5: With `gap_i` = 0, `cs_no` stays low between busy checks. With `gap_i` = G > 0, `cs_no` is released for exactly G clocks between checks.
- R6: `sdo_i` is sampled on each rising edge of `sck_o`. The second through 24th samples land in `data_o[22]` down to `data_o[0]`, in that order.
- R7: `cs_no` rises one clock after the 24th falling edge of `sck_o`. One clock later `valid_o` pulses for a single cycle, and `data_o` then holds until the next valid pulse.
- R8: A frame whose first sample is 1 gives no valid pulse, sets `err_o` and leaves `data_o` unchanged.
- R9: With `timeout_i` = T > 0, T busy reads in a row set `err_o`, raise `cs_no` with no `sck_o` edge and return the reader to idle. With T = 0 polling never gives up.
- R10: An `abort_i` during an active read raises `cs_no` and lowers `sck_o` on the next clock, with no valid pulse and no change to `data_o`.
- R11: After reset, `cs_no` = 1, `sck_o` = 0, `valid_o` = 0, `err_o` = 0 and `data_o` = 0.
- R12: `err_o` is cleared when a read starts and then holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a reading (taken while idle) |
| abort_i | input | 1 | Cancel the read in progress |
| half_div_i | input | DIV_W | Serial clock half-period in system clocks (below 2 acts as 2) |
| gap_i | input | GAP_W | Select-released gap between busy checks, 0 keeps select low |
| timeout_i | input | TMO_W | Busy-read limit, 0 disables the limit |
| sdo_i | input | 1 | Serial data / busy flag from the converter |
| cs_no | output | 1 | Active-low chip select |
| sck_o | output | 1 | Serial clock to the converter |
| data_o | output | FRAME_BITS-1 | Last valid result |
| err_o | output | 1 | Poll timeout or frame with a set first bit |
| valid_o | output | 1 | One-cycle pulse when `data_o` holds a new result |

## Verification
A converter model answers every read. It holds the data line high for a fixed conversion time and then shifts out its word on falling clock edges. The sweep covers half-period settings 0 to 4 crossed with gaps 0, 3 and 6. This separates the clamped divider from the programmed one, and continuous-select polling from released-select polling, each with the measured gap width. Words of all zeros, all ones and alternating bits expose bit order and stuck bits. A converter that never becomes ready is used with and without a poll limit, to tell timeout from endless polling. A mid-frame abort and a frame whose first bit turns to one are used to tell discarded frames from delivered ones.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_GAP,
    ST_SHIFT,
    ST_STOP,
    ST_DONE
  } rd_state_e;

  // Effective half-period in system clocks: never below two.
  function automatic int unsigned eff_half(input int unsigned req);
    return (req < 2) ? 2 : req;
  endfunction

  // True when the number of busy reads has reached a nonzero limit.
  function automatic logic timeout_hit(input int unsigned reads, input int unsigned limit);
    return (limit != 0) && (reads >= limit);
  endfunction

  // A frame is accepted when its first sampled bit (the flag) is clear.
  function automatic logic frame_accepted(input logic first_bit);
    return !first_bit;
  endfunction

endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick
  import adc_rd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last_c;

  assign last_c = DIV_W'(eff_half(32'(half_i)) - 32'd1);
  assign tick_o = run_i && (cnt_q == last_c);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: a half-period is at least two system clocks, so ticks never touch
  assert_tick_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int NBITS = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             smp_i,
  input  logic             bit_i,
  output logic [NBITS-1:0] word_o,
  output logic             full_o
);

  localparam int CW = $clog2(NBITS + 1);

  logic [CW-1:0]    cnt_q;
  logic [NBITS-1:0] word_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      word_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      word_q <= '0;
    end else if (smp_i) begin
      cnt_q  <= cnt_q + 1'b1;
      word_q <= {word_q[NBITS-2:0], bit_i};
    end
  end

  assign word_o = word_q;
  assign full_o = (cnt_q == CW'(NBITS));

  // R3: the controller never asks for a sample beyond the frame length
  assert_no_extra_sample_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_i |-> !full_o);

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adc_rd_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int GAP_W      = 8,
  parameter int TMO_W      = 16,
  parameter int FRAME_BITS = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  abort_i,
  input  logic [DIV_W-1:0]      half_div_i,
  input  logic [GAP_W-1:0]      gap_i,
  input  logic [TMO_W-1:0]      timeout_i,
  input  logic                  sdo_i,
  output logic                  cs_no,
  output logic                  sck_o,
  output logic [FRAME_BITS-2:0] data_o,
  output logic                  err_o,
  output logic                  valid_o
);

  localparam int DATA_W = FRAME_BITS - 1;

  rd_state_e         state_q;
  logic              cs_n_q, sck_q, err_q, valid_q;
  logic [TMO_W-1:0]  poll_q;
  logic [GAP_W-1:0]  gap_q;
  logic [DATA_W-1:0] data_q;

  // Named internal events
  logic                  active, run, tick;
  logic                  poll_tick, ready_read, busy_read, give_up;
  logic                  rise_ev, fall_ev, gap_done, clr_frame;
  logic                  frame_full, frame_good;
  logic [TMO_W-1:0]      poll_next;
  logic [FRAME_BITS-1:0] frame_word;

  assign active     = (state_q != ST_IDLE);
  assign run        = (state_q == ST_SETTLE) || (state_q == ST_SHIFT);
  assign poll_tick  = (state_q == ST_SETTLE) && tick;
  assign ready_read = poll_tick && !sdo_i;
  assign busy_read  = poll_tick && sdo_i;
  assign poll_next  = poll_q + 1'b1;
  assign give_up    = busy_read && timeout_hit(32'(poll_next), 32'(timeout_i));
  assign rise_ev    = (state_q == ST_SHIFT) && tick && !sck_q;
  assign fall_ev    = (state_q == ST_SHIFT) && tick && sck_q;
  assign gap_done   = (state_q == ST_GAP) && (gap_q == gap_i - GAP_W'(1));
  assign clr_frame  = (state_q == ST_IDLE) && start_i;
  assign frame_good = frame_accepted(frame_word[FRAME_BITS-1]);

  adc_rd_tick #(.DIV_W(DIV_W)) tick_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .half_i (half_div_i),
    .tick_o (tick)
  );

  adc_rd_shift #(.NBITS(FRAME_BITS)) shift_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_frame),
    .smp_i  (rise_ev),
    .bit_i  (sdo_i),
    .word_o (frame_word),
    .full_o (frame_full)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sck_q   <= 1'b0;
      poll_q  <= '0;
      gap_q   <= '0;
      err_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (abort_i && active) begin
        state_q <= ST_IDLE;
        cs_n_q  <= 1'b1;
        sck_q   <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (start_i) begin
              cs_n_q  <= 1'b0;
              sck_q   <= 1'b0;
              poll_q  <= '0;
              err_q   <= 1'b0;
              state_q <= ST_SETTLE;
            end
          end
          ST_SETTLE: begin
            if (ready_read) begin
              state_q <= ST_SHIFT;
            end else if (give_up) begin
              err_q   <= 1'b1;
              cs_n_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (busy_read) begin
              poll_q <= poll_next;
              if (gap_i != '0) begin
                cs_n_q  <= 1'b1;
                gap_q   <= '0;
                state_q <= ST_GAP;
              end
            end
          end
          ST_GAP: begin
            if (gap_done) begin
              cs_n_q  <= 1'b0;
              state_q <= ST_SETTLE;
            end else begin
              gap_q <= gap_q + 1'b1;
            end
          end
          ST_SHIFT: begin
            if (rise_ev) begin
              sck_q <= 1'b1;
            end else if (fall_ev) begin
              sck_q <= 1'b0;
              if (frame_full) state_q <= ST_STOP;
            end
          end
          ST_STOP: begin
            cs_n_q  <= 1'b1;
            state_q <= ST_DONE;
          end
          ST_DONE: begin
            if (frame_good) begin
              valid_q <= 1'b1;
              data_q  <= frame_word[DATA_W-1:0];
            end else begin
              err_q <= 1'b1;
            end
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign cs_no   = cs_n_q;
  assign sck_o   = sck_q;
  assign data_o  = data_q;
  assign err_o   = err_q;
  assign valid_o = valid_q;

  // R1: select only falls with the serial clock low
  assert_select_with_sck_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_q) |-> !sck_q);
  // R1: serial clock high only inside a selected window
  assert_sck_inside_select_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_q |-> !cs_n_q);
  // R3: a busy read never leads into clocking
  assert_no_clock_while_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_read |=> !sck_q && (state_q != ST_SHIFT));
  // R5: select stays released through the whole idle gap
  assert_gap_keeps_deselect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |-> cs_n_q);
  // R7: the valid pulse comes after select has risen
  assert_valid_after_deselect_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> cs_n_q && $past(cs_n_q));
  // R7: valid lasts one cycle
  assert_valid_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R9: a timeout leaves select released and reports no data
  assert_timeout_deselects_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> cs_n_q && !valid_q);
  // R10: abort releases the link on the next clock
  assert_abort_releases_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && active) |=> cs_n_q && !sck_q && !valid_q);

endmodule

// File: tb/adc_serial_reader_tb_top.sv
module adc_serial_reader_tb_top;

  localparam int CONV = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, abort = 1'b0;
  logic [7:0]  half = 8'd2, gap = 8'd0;
  logic [15:0] tmo = 16'd0;
  logic        sdo, cs_n, sck, err, valid;
  logic [22:0] data;

  // 4 ns period: 250 MHz
  always #2 clk = ~clk;

  adc_serial_reader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort),
    .half_div_i(half), .gap_i(gap), .timeout_i(tmo), .sdo_i(sdo),
    .cs_no(cs_n), .sck_o(sck), .data_o(data), .err_o(err), .valid_o(valid)
  );

  // ---------------- converter model ----------------
  int          busy;
  logic        act, m_prev_cs, m_prev_sck;
  logic [23:0] sh;
  int          falls_m;
  bit          stuck = 1'b0;
  bit          ovr_en = 1'b0, ovr_val = 1'b0;
  logic [22:0] model_word = '0;
  int          r3_bad = 0;
  logic        sdo_m;

  always @(posedge clk) begin
    if (!rst_n) begin
      busy <= CONV; act <= 1'b0; sh <= '0; falls_m <= 0;
      m_prev_cs <= 1'b1; m_prev_sck <= 1'b0;
    end else begin
      if (busy > 0 && !stuck) busy <= busy - 1;
      if (cs_n && !m_prev_cs && act) begin
        act <= 1'b0; busy <= CONV;
      end else if (!cs_n && sck && !m_prev_sck) begin
        if (!act) begin
          if (busy > 0 || stuck) r3_bad <= r3_bad + 1;
          act <= 1'b1; sh <= {1'b0, model_word}; falls_m <= 0;
        end
      end else if (!sck && m_prev_sck && act) begin
        sh <= sh << 1;
        if (falls_m == 23) begin act <= 1'b0; busy <= CONV; end
        falls_m <= falls_m + 1;
      end
      m_prev_cs  <= cs_n;
      m_prev_sck <= sck;
    end
  end

  assign sdo_m = act ? sh[23] : ((busy > 0 || stuck) ? 1'b1 : 1'b0);
  assign sdo   = ovr_en ? ovr_val : (cs_n ? 1'b1 : sdo_m);

  // ---------------- port monitor ----------------
  int exp_half = 2, exp_gap = 0;
  int rises, hi_len, lo_len, width_bad, cs_falls, cs_hi_len, gap_bad, r1_bad, valids, r7_bad;
  logic [22:0] last_data;
  logic prev_cs = 1'b1, prev_sck = 1'b0;

  task automatic clr_mon();
    rises = 0; hi_len = 0; lo_len = 0; width_bad = 0; cs_falls = 0; cs_hi_len = 0;
    gap_bad = 0; r1_bad = 0; valids = 0; r7_bad = 0; r3_bad = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && prev_cs) begin
        cs_falls++;
        if (sck) r1_bad++;
        if (cs_falls > 1 && cs_hi_len != exp_gap) gap_bad++;
      end
      if (cs_n) cs_hi_len = prev_cs ? cs_hi_len + 1 : 1;
      if (sck && cs_n) r1_bad++;
      if (sck && !prev_sck) begin
        rises++;
        if (rises > 1 && lo_len != exp_half) width_bad++;
        hi_len = 0;
      end
      if (sck) hi_len++;
      if (!sck && prev_sck) begin
        if (hi_len != exp_half) width_bad++;
        lo_len = 0;
      end
      if (!sck) lo_len++;
      if (valid) begin
        valids++; last_data = data;
        if (!cs_n) r7_bad++;
      end
      prev_cs = cs_n; prev_sck = sck;
    end
  end

  // ---------------- checking helpers ----------------
  int total = 0, bad = 0;

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input bit ok, input string req, input longint act_v, input longint exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1; step(1); start = 1'b0;
  endtask

  task automatic run_frame(input int h, input int g, input logic [22:0] w);
    half = 8'(h); gap = 8'(g); tmo = 16'd0;
    exp_half = (h < 2) ? 2 : h; exp_gap = g; model_word = w;
    clr_mon();
    pulse_start();
    for (int n = 0; n < 4000 && valids == 0; n++) step(1);
    step(3);
    chk(valids == 1, "R7 valid count", valids, 1);
    chk(r7_bad == 0, "R7 valid with select low", r7_bad, 0);
    chk(last_data == w, "R6 captured word", last_data, w);
    chk(data == w, "R7 data held", data, w);
    chk(rises == 24, "R3 rising edges", rises, 24);
    chk(r3_bad == 0, "R3 clock while busy", r3_bad, 0);
    chk(width_bad == 0, "R4 phase width", width_bad, 0);
    chk(gap_bad == 0, "R5 gap width", gap_bad, 0);
    if (g == 0) chk(cs_falls == 1, "R5 select held while polling", cs_falls, 1);
    else        chk(cs_falls > 1, "R2 repeated status checks", cs_falls, 2);
    chk(r1_bad == 0, "R1 select/clock relation", r1_bad, 0);
    chk(err == 1'b0, "R12 error clear", err, 0);
  endtask

  task automatic main_seq();
    logic [22:0] prev;
    step(4); rst_n = 1'b1; step(2);
    chk(cs_n == 1'b1, "R11 cs", cs_n, 1);
    chk(sck == 1'b0, "R11 sck", sck, 0);
    chk(valid == 1'b0, "R11 valid", valid, 0);
    chk(err == 1'b0, "R11 err", err, 0);
    chk(data == '0, "R11 data", data, 0);

    // sweep over half-period and gap settings
    for (int h = 0; h < 5; h++)
      for (int gi = 0; gi < 3; gi++)
        run_frame(h, gi * 3, 23'((32'(h * 3 + gi + 1) * 32'h0013_579B) ^ (32'(h) << 17)));
    run_frame(2, 0, 23'h000000);
    run_frame(2, 0, 23'h7FFFFF);
    run_frame(3, 0, 23'h555555);

    // R9: converter never ready, limit of 5 reads
    stuck = 1'b1; half = 8'd2; gap = 8'd2; tmo = 16'd5; exp_half = 2; exp_gap = 2;
    clr_mon(); pulse_start(); step(300);
    chk(err == 1'b1, "R9 timeout error", err, 1);
    chk(cs_n == 1'b1, "R9 released", cs_n, 1);
    chk(rises == 0, "R9 no clocks", rises, 0);
    chk(cs_falls == 5, "R9 read count", cs_falls, 5);
    chk(valids == 0, "R9 no valid", valids, 0);
    chk(gap_bad == 0, "R5 gap width in timeout", gap_bad, 0);

    // R9 with no limit, then R10 abort while polling
    tmo = 16'd0; clr_mon(); pulse_start();
    chk(err == 1'b0, "R12 error cleared at start", err, 0);
    step(200);
    chk(err == 1'b0, "R9 no limit keeps polling", err, 0);
    chk(cs_falls > 5, "R9 still polling", cs_falls, 6);
    abort = 1'b1; step(1); abort = 1'b0;
    chk(cs_n == 1'b1 && sck == 1'b0, "R10 abort in poll", {cs_n, sck}, 2);
    step(20);
    chk(cs_n == 1'b1, "R10 stays idle", cs_n, 1);
    stuck = 1'b0;
    step(80);

    // R10 abort in the middle of a frame
    run_frame(2, 0, 23'h12_3456);
    prev = data;
    half = 8'd3; gap = 8'd0; exp_half = 3; exp_gap = 0; model_word = 23'h6A_BCDE;
    step(80);
    clr_mon(); pulse_start();
    for (int n = 0; n < 2000 && rises < 10; n++) step(1);
    abort = 1'b1; step(1); abort = 1'b0;
    chk(cs_n == 1'b1, "R10 abort releases select", cs_n, 1);
    chk(sck == 1'b0, "R10 abort lowers clock", sck, 0);
    step(40);
    chk(valids == 0, "R10 no valid after abort", valids, 0);
    chk(data == prev, "R10 data unchanged", data, prev);
    chk(err == 1'b0, "R10 no error", err, 0);
    run_frame(3, 3, 23'h2B_C0DE);

    // R8 frame whose first sampled bit is 1
    step(100);
    prev = data;
    half = 8'd4; gap = 8'd0; exp_half = 4; exp_gap = 0;
    ovr_en = 1'b1; ovr_val = 1'b0;
    clr_mon(); pulse_start();
    step(5);
    ovr_val = 1'b1;
    for (int n = 0; n < 2000 && !(cs_n && rises > 0); n++) step(1);
    step(5);
    chk(rises == 24, "R8 full frame clocked", rises, 24);
    chk(valids == 0, "R8 no valid", valids, 0);
    chk(err == 1'b1, "R8 error set", err, 1);
    chk(data == prev, "R8 data unchanged", data, prev);
    ovr_en = 1'b0;
    step(100);
    run_frame(2, 0, 23'h0F_0F0F);
  endtask

  initial begin
    bit timed_out = 1'b0;
    fork
      main_seq();
      begin step(150000); timed_out = 1'b1; end
    join_any
    disable fork;
    if (timed_out) chk(1'b0, "watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule